// File: doc/BRIEF.md
# Processor Bus Cycle Decoder

This block sits beside a 64-bit host processor bus and decodes each bus cycle. When the address strobe is low and no cycle is open, it registers the three cycle-type pins and the two cacheability pins. From the next clock it drives one of eight strobes for board logic: interrupt acknowledge, special cycle, I/O read, I/O write, code fetch, invalid, memory read or memory write. The board uses these strobes to build chip selects and output enables.

Alongside the strobe, a burst flag tells the board whether the cycle moves one transfer (up to 8 bytes) or four transfers (a 32-byte line). The decode stays constant through any wait states. It clears in the clock after the ready input marks the final transfer.

Two kinds of bus misuse set sticky flags that only reset clears. One is a cacheable cycle in I/O space. The other is an address strobe that arrives while a cycle is still open.

Top module: `proc_cycle_dec`

## Requirements
- R1: The cycle-type and cacheability inputs are sampled only on a rising clock where `ads_n` is 0 and no cycle is open. Strobes appear from the next clock.
- R2: Strobe index equals the sampled value {`mio_n`,`dc_n`,`wr_n`}: 0 interrupt acknowledge, 1 special cycle, 2 I/O read, 3 I/O write, 4 code read, 5 invalid, 6 memory read, 7 memory write. Exactly one strobe is high while a cycle is open, and none is high otherwise.
- R3: While a cycle is open, the strobes and the burst flag stay stable through wait states (`brdy_n` high), whatever the cycle inputs do.
- R4: A code read (4) or memory read (6) is a four-transfer burst when `cache_n` and `ken_n` were both 0 at capture. Otherwise it is a single transfer.
- R5: A memory write (7) is a four-transfer burst when `cache_n` was 0, whatever `ken_n` was. Codes 0, 1, 2, 3 and 5 are always single transfers, and interrupt acknowledge is decoded as two separate single cycles.
- R6: A cycle ends on the rising clock that samples its last `brdy_n` low: the first one for a single transfer, the fourth for a burst. Strobes and `burst` are 0 from the next clock. `brdy_n` low while no cycle is open is ignored.
- R7: If `cache_n` is 0 while `mio_n` is 0 at capture, `proto_err` goes to 1 and stays there. That cycle is still decoded, as a single transfer.
- R8: If `ads_n` is 0 while a cycle is open, `overlap_err` goes to 1 and stays there. The strobe is ignored and the open cycle's decode is unchanged.
- R9: While `rst_n` is 0, all strobes, `burst`, `proto_err` and `overlap_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| mio_n | input | 1 | 1 memory, 0 I/O |
| dc_n | input | 1 | 1 data, 0 code or control |
| wr_n | input | 1 | 1 write, 0 read |
| cache_n | input | 1 | Processor cacheability indication, active low |
| ken_n | input | 1 | Board cache enable, active low |
| brdy_n | input | 1 | Transfer ready, active low |
| cyc_stb | output | 8 | One-hot decoded cycle strobes, indexed by cycle code |
| burst | output | 1 | Open cycle is a four-transfer burst |
| proto_err | output | 1 | Sticky: cacheable I/O cycle seen |
| overlap_err | output | 1 | Sticky: address strobe during open cycle |

## Verification
The assertions assume a bus whose inputs are settled at each rising clock. They also assume that `ken_n` is valid together with the address strobe rather than at the first ready. The bench changes inputs only on falling edges. It inverts the cycle inputs during wait states so that the hold property is exercised. Cacheable I/O cycles and overlapping strobes are produced only on purpose, so the sticky flags are checked where they are expected to rise.

// File: rtl/proc_cycle_dec.sv
module proc_cycle_dec #(
  parameter int BURST_BEATS = 4,
  parameter int NUM_KINDS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ads_n,
  input  logic                 mio_n,
  input  logic                 dc_n,
  input  logic                 wr_n,
  input  logic                 cache_n,
  input  logic                 ken_n,
  input  logic                 brdy_n,
  output logic [NUM_KINDS-1:0] cyc_stb,
  output logic                 burst,
  output logic                 proto_err,
  output logic                 overlap_err
);

  localparam int CW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam int KW = $clog2(NUM_KINDS);
  localparam logic [CW-1:0] LAST_BEAT = CW'(BURST_BEATS - 1);

  logic          open_q;
  logic [KW-1:0] kind_q;
  logic          burst_q;
  logic [CW-1:0] beat_q;

  wire [KW-1:0] kind_in   = KW'({mio_n, dc_n, wr_n});
  wire          rd_fill   = mio_n & ~wr_n & ~cache_n & ~ken_n;
  wire          wr_back   = mio_n & dc_n & wr_n & ~cache_n;
  wire          start     = ~ads_n & ~open_q;
  wire          beat_done = open_q & ~brdy_n;
  wire          last      = beat_done & (~burst_q | (beat_q == LAST_BEAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      kind_q  <= '0;
      burst_q <= 1'b0;
      beat_q  <= '0;
    end else if (start) begin
      open_q  <= 1'b1;
      kind_q  <= kind_in;
      burst_q <= rd_fill | wr_back;
      beat_q  <= '0;
    end else if (last) begin
      open_q  <= 1'b0;
      burst_q <= 1'b0;
      beat_q  <= '0;
    end else if (beat_done) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proto_err   <= 1'b0;
      overlap_err <= 1'b0;
    end else begin
      if (start && !cache_n && !mio_n) proto_err <= 1'b1;
      if (!ads_n && open_q) overlap_err <= 1'b1;
    end
  end

  assign cyc_stb = open_q ? (NUM_KINDS'(1) << kind_q) : '0;
  assign burst   = open_q & burst_q;

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cyc_stb));

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && cyc_stb == '0) |=> cyc_stb == (NUM_KINDS'(1) << $past(kind_in)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb != '0 && brdy_n && ads_n) |=> ($stable(cyc_stb) && $stable(burst)));

  a_r5_burst_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> (cyc_stb[4] || cyc_stb[6] || cyc_stb[7]));

  a_r6_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb != '0 && !burst && !brdy_n) |=> cyc_stb == '0);

  a_r7_proto: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && cyc_stb == '0 && !cache_n && !mio_n) |=> (proto_err && !burst));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> overlap_err);

  a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && cyc_stb != '0 && brdy_n) |=> (overlap_err && $stable(cyc_stb)));

endmodule

// File: tb/sim_proc_cycle_dec.sv
module sim_proc_cycle_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ads_n = 1'b1, mio_n = 1'b1, dc_n = 1'b1, wr_n = 1'b1;
  logic cache_n = 1'b1, ken_n = 1'b1, brdy_n = 1'b1;
  logic [7:0] cyc_stb;
  logic burst, proto_err, overlap_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  proc_cycle_dec u0 (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio_n(mio_n), .dc_n(dc_n),
    .wr_n(wr_n), .cache_n(cache_n), .ken_n(ken_n), .brdy_n(brdy_n),
    .cyc_stb(cyc_stb), .burst(burst), .proto_err(proto_err),
    .overlap_err(overlap_err)
  );

  // {mio_n,dc_n,wr_n,cache_n,ken_n}, expected strobes, burst, proto_err after capture
  localparam logic [14:0] VEC [0:11] = '{
    {5'b00011, 8'h01, 1'b0, 1'b0},
    {5'b00111, 8'h02, 1'b0, 1'b0},
    {5'b01011, 8'h04, 1'b0, 1'b0},
    {5'b01111, 8'h08, 1'b0, 1'b0},
    {5'b10000, 8'h10, 1'b1, 1'b0},
    {5'b10010, 8'h10, 1'b0, 1'b0},
    {5'b10100, 8'h20, 1'b0, 1'b0},
    {5'b11000, 8'h40, 1'b1, 1'b0},
    {5'b11011, 8'h40, 1'b0, 1'b0},
    {5'b11101, 8'h80, 1'b1, 1'b0},
    {5'b11111, 8'h80, 1'b0, 1'b0},
    {5'b01001, 8'h04, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cycle(input logic [4:0] f, input logic [7:0] es,
                          input logic eb, input logic ep);
    int n;
    {mio_n, dc_n, wr_n, cache_n, ken_n} = f;
    ads_n = 1'b0;
    @(negedge clk);
    ads_n = 1'b1;
    {mio_n, dc_n, wr_n, cache_n, ken_n} = ~f;
    check("R1 R2 strobe", 32'(cyc_stb), 32'(es));
    check("R4 R5 burst", 32'(burst), 32'(eb));
    check("R7 proto_err", 32'(proto_err), 32'(ep));
    n = eb ? 4 : 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R3 hold in wait state", 32'({burst, cyc_stb}), 32'({eb, es}));
      brdy_n = 1'b0;
      @(negedge clk);
      brdy_n = 1'b1;
      if (i < n - 1)
        check("R6 open before last beat", 32'(cyc_stb), 32'(es));
      else
        check("R6 cleared after last beat", 32'({burst, cyc_stb}), 32'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outputs", 32'({proto_err, overlap_err, burst, cyc_stb}), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 12; k++)
      do_cycle(VEC[k][14:10], VEC[k][9:2], VEC[k][1], VEC[k][0]);

    // R8: strobe during an open single memory read
    {mio_n, dc_n, wr_n, cache_n, ken_n} = 5'b11011;
    ads_n = 1'b0;
    @(negedge clk);
    ads_n = 1'b1;
    check("R8 no error yet", 32'(overlap_err), 32'(0));
    {mio_n, dc_n, wr_n, cache_n, ken_n} = 5'b01111;
    ads_n = 1'b0;
    @(negedge clk);
    ads_n = 1'b1;
    check("R8 overlap flagged", 32'(overlap_err), 32'(1));
    check("R8 decode kept", 32'(cyc_stb), 32'h40);
    brdy_n = 1'b0;
    @(negedge clk);
    brdy_n = 1'b1;
    check("R8 cycle closed", 32'(cyc_stb), 32'(0));
    @(negedge clk);
    check("R8 flag sticky", 32'(overlap_err), 32'(1));

    // R6: ready while idle is ignored; a following burst still needs four beats
    brdy_n = 1'b0;
    repeat (2) @(negedge clk);
    brdy_n = 1'b1;
    check("R6 idle ready ignored", 32'(cyc_stb), 32'(0));
    do_cycle(5'b11000, 8'h40, 1'b1, 1'b1);

    // R9: reset clears the sticky flags
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 flags cleared", 32'({proto_err, overlap_err, burst, cyc_stb}), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    do_cycle(5'b10001, 8'h10, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule